// File: doc/BRIEF.md
# LCD Panel Sync Timing Generator

This block produces the scan timing for a parallel LCD panel: horizontal and vertical sync, a data-enable (bias) strobe, a pixel clock with its one-cycle enable, a frame-start pulse, and the column and row of the pixel being shown. A pixel slot lasts a whole number of input clocks, set by a divisor field. The horizontal and vertical shapes are each described by one packed 32-bit timing word, with every field stored as its count minus one. A clock word holds the divisor and one polarity bit for each of the four panel-facing signals.

Software loads four words through a simple write port: a control word whose bit 0 starts and stops scanning, the horizontal and vertical timing words, and the clock word. While the block is stopped, written values reach the timing logic one cycle later. While it is scanning, they are held back and applied at the next frame start, so a frame is never drawn with mixed timing. The counters are sized for panels up to 800 pixels by 600 lines.

Top module: `lcd_sync_gen`

## Requirements
- R1: A write (`wr_en` high) stores `wr_data` into the word picked by `wr_addr`: 0 is control (bit 0 = run), 1 is horizontal timing, 2 is vertical timing, 3 is the clock word. Writing the control word with bit 0 set starts scanning at the next clock edge.
- R2: After reset all four words are zero and the block is stopped. `pix_ce`, `pix_clk`, `hsync`, `vsync`, `de`, `frame_start`, `x_pos` and `y_pos` are all 0.
- R3: While scanning, `pix_ce` is high for one clock in every 2*(D+1) clocks, where D is clock word bits [9:0]. The raw pixel clock is low for the first D+1 clocks of each slot and high for the rest. `pix_ce` is high on the last clock of the slot.
- R4: A line consists of four parts in this order: sync for [15:10]+1 slots, back porch for [23:16]+1, active for [9:0]+1, front porch for [31:24]+1. The counts come from the horizontal word, and the raw `hsync` is high during the sync part. Positions change only on `pix_ce`.
- R5: The vertical word uses the same field layout, in lines. The line counter advances on the `pix_ce` that ends each line, and the raw `vsync` is high during the vertical sync lines.
- R6: The raw `de` is high only when both the horizontal and the vertical position are inside their active parts. `x_pos` is the column within the horizontal active part and is 0 outside it. `y_pos` is the row within the vertical active part and is 0 outside it.
- R7: Clock word bit 15 inverts `vsync`, bit 16 inverts `hsync`, bit 17 inverts `pix_clk` and bit 18 inverts `de`. The inversion also applies to the levels driven while stopped.
- R8: Clearing control bit 0 stops scanning on the next edge. The counters return to the origin (the first sync slot of the first sync line), `pix_ce`, `frame_start`, `x_pos` and `y_pos` are 0, and the raw sync, clock and enable are low. Setting the bit again resumes scanning from the origin.
- R9: While scanning, writes to words 1 to 3 take effect only from the next frame start. While stopped, they take effect one clock after the write.
- R10: `frame_start` is high on the `pix_ce` of the first slot of each frame, which is the origin position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 horizontal, 2 vertical, 3 clock) |
| wr_data | input | 32 | Register write data |
| pix_ce | output | 1 | One-cycle pixel enable |
| pix_clk | output | 1 | Pixel clock to the panel, polarity applied |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable / bias, polarity applied |
| frame_start | output | 1 | Pulse on the first pixel enable of each frame |
| x_pos | output | 10 | Active column, 0 outside the active part |
| y_pos | output | 10 | Active row, 0 outside the active part |

## Verification
Several events can fall in the same input cycle. The most delicate pair is the pixel enable that ends the last line of a frame together with a register write to a timing word. Here the wrap to the origin must pick up the staged value that was already present, and the word that has just arrived must wait for the following frame. The bench provokes this with random rewrites at random points while scanning, and with a directed rewrite right after a frame start. It judges the result by comparing every output in every cycle against its own slot, line and frame model. It also measures the two frame periods on either side of the change.

// File: rtl/lcd_sync_pkg.sv
// Package: shared field layouts and register addresses for the LCD sync
// timing generator. Assumes 32-bit register words.
package lcd_sync_pkg;

    // Register select codes on the write port
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_HTIM = 2'd1;
    localparam logic [1:0] REG_VTIM = 2'd2;
    localparam logic [1:0] REG_CLK  = 2'd3;

    // Packed axis timing word; every field holds count minus one
    typedef struct packed {
        logic [7:0] porch_front;   // after active, before sync
        logic [7:0] porch_back;    // after sync, before active
        logic [5:0] pulse_m1;      // sync width
        logic [9:0] active_m1;     // active pixels or lines
    } lcd_tim_t;

    // Fields kept from the clock word
    typedef struct packed {
        logic       inv_de;
        logic       inv_pclk;
        logic       inv_hs;
        logic       inv_vs;
        logic [9:0] divisor;
    } lcd_clk_t;

    // Extract the used bits of a raw clock word
    function automatic lcd_clk_t clk_from_word(input logic [31:0] w);
        lcd_clk_t c;
        c.inv_de   = w[18];
        c.inv_pclk = w[17];
        c.inv_hs   = w[16];
        c.inv_vs   = w[15];
        c.divisor  = w[9:0];
        return c;
    endfunction

endpackage

// File: rtl/lcd_tim_regs.sv
// Register bank: the write port loads staging copies of the control, timing
// and clock words; shadow copies used by the scan logic are refreshed from
// staging whenever load is high (stopped, or the frame's final enable).
// Assumes one write per cycle at most.
module lcd_tim_regs
    import lcd_sync_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        load,
    output logic        go,
    output lcd_tim_t    htim,
    output lcd_tim_t    vtim,
    output lcd_clk_t    clkw
);

    lcd_tim_t h_stg, v_stg;
    lcd_clk_t c_stg;

    // Staging registers written by the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go    <= 1'b0;
            h_stg <= '0;
            v_stg <= '0;
            c_stg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL: go    <= wr_data[0];
                REG_HTIM: h_stg <= lcd_tim_t'(wr_data);
                REG_VTIM: v_stg <= lcd_tim_t'(wr_data);
                default:  c_stg <= clk_from_word(wr_data);
            endcase
        end
    end

    // Shadow copies seen by the timing logic, refreshed on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htim <= '0;
            vtim <= '0;
            clkw <= '0;
        end else if (load) begin
            htim <= h_stg;
            vtim <= v_stg;
            clkw <= c_stg;
        end
    end

endmodule

// File: rtl/lcd_pix_div.sv
// Pixel slot divider: a slot lasts 2*(divisor+1) clocks; the raw pixel clock
// is low for the first half and high for the second; the enable marks the
// last clock of the slot. Held at slot start while run is low.
module lcd_pix_div #(
    parameter int DIV_BITS = 10,
    localparam int CNT_W   = DIV_BITS + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [DIV_BITS-1:0] divisor,
    output logic                ce,
    output logic                pclk_raw
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit    = {divisor, 1'b1};
    assign ce       = run && (cnt_q == limit);
    assign pclk_raw = run && (cnt_q > {1'b0, divisor});

    // Slot counter: wraps on the enable, cleared while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R3: a slot is at least two clocks, so the enable never repeats back to back
    p_ce_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> !ce);

    // R8: no enable while stopped
    p_div_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !ce);

endmodule

// File: rtl/lcd_axis_ctr.sv
// One scan axis (used for both columns and rows): counts slots in the order
// sync, back porch, active, front porch, advancing on step and cleared while
// stopped. Assumes the timing word changes only when the count is at zero.
module lcd_axis_ctr
    import lcd_sync_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  lcd_tim_t         tim,
    output logic             sync_o,
    output logic             act_o,
    output logic             first_o,
    output logic             last_o,
    output logic [POS_W-1:0] pos_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] sync_end, act_beg, act_end, period, rel;

    // Segment boundaries from the minus-one fields
    always_comb begin
        sync_end = CNT_W'(tim.pulse_m1) + ONE;
        act_beg  = sync_end + CNT_W'(tim.porch_back) + ONE;
        act_end  = act_beg + CNT_W'(tim.active_m1) + ONE;
        period   = act_end + CNT_W'(tim.porch_front) + ONE;
        rel      = cnt_q - act_beg;
    end

    assign sync_o  = run && (cnt_q < sync_end);
    assign act_o   = run && (cnt_q >= act_beg) && (cnt_q < act_end);
    assign first_o = (cnt_q == '0);
    assign last_o  = (cnt_q == period - ONE);
    assign pos_o   = act_o ? rel[POS_W-1:0] : '0;

    // Position counter: advances on step, wraps at the period end
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= last_o ? '0 : cnt_q + ONE;
        end
    end

    // R4/R5: position only moves on a step
    p_hold_no_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> $stable(cnt_q));

    // R4/R5: position never leaves the programmed period
    p_in_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < period));

endmodule

// File: rtl/lcd_sync_gen.sv
// LCD sync timing generator top: register bank, pixel slot divider and two
// scan axes, with per-signal polarity applied at the outputs. Assumes the
// timing fields describe panels up to 800x600 (counters sized by CNT_W).
module lcd_sync_gen
    import lcd_sync_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int POS_W    = 10,
    parameter int DIV_BITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    output logic             pix_ce,
    output logic             pix_clk,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             frame_start,
    output logic [POS_W-1:0] x_pos,
    output logic [POS_W-1:0] y_pos
);

    logic     go, load, frame_end, ce, pclk_raw;
    lcd_tim_t htim, vtim;
    lcd_clk_t clkw;
    logic     hs_raw, h_act, h_first, h_last;
    logic     vs_raw, v_act, v_first, v_last;
    logic     de_raw;

    assign frame_end = ce && h_last && v_last;
    assign load      = !go || frame_end;

    lcd_tim_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .go      (go),
        .htim    (htim),
        .vtim    (vtim),
        .clkw    (clkw)
    );

    lcd_pix_div #(.DIV_BITS(DIV_BITS)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (go),
        .divisor  (clkw.divisor),
        .ce       (ce),
        .pclk_raw (pclk_raw)
    );

    lcd_axis_ctr #(.CNT_W(CNT_W), .POS_W(POS_W)) u_hax (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (go),
        .step    (ce),
        .tim     (htim),
        .sync_o  (hs_raw),
        .act_o   (h_act),
        .first_o (h_first),
        .last_o  (h_last),
        .pos_o   (x_pos)
    );

    lcd_axis_ctr #(.CNT_W(CNT_W), .POS_W(POS_W)) u_vax (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (go),
        .step    (ce && h_last),
        .tim     (vtim),
        .sync_o  (vs_raw),
        .act_o   (v_act),
        .first_o (v_first),
        .last_o  (v_last),
        .pos_o   (y_pos)
    );

    // Output stage: combine axes and apply the polarity bits
    always_comb begin
        de_raw      = h_act && v_act;
        pix_ce      = ce;
        frame_start = ce && h_first && v_first;
        pix_clk     = pclk_raw ^ clkw.inv_pclk;
        hsync       = hs_raw ^ clkw.inv_hs;
        vsync       = vs_raw ^ clkw.inv_vs;
        de          = de_raw ^ clkw.inv_de;
    end

    // R8: stopped means blank
    p_blank_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !go |-> (!de_raw && !frame_start && !hs_raw && !vs_raw));

    // R10: the frame pulse falls in the origin slot, inside both sync parts
    p_fs_at_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (hs_raw && vs_raw));

    // R6: active video never overlaps horizontal sync
    p_de_outside_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> !hs_raw);

endmodule

// File: tb/lcd_sync_gen_tb.sv
// Bench: a slot/line/frame reference model, updated on each rising edge from
// the driven writes, compared with every output at each falling edge. Random
// timing plus directed checks of reset, start, deferral, polarity and stop.
module lcd_sync_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pix_ce, pix_clk, hsync, vsync, de, frame_start;
    logic [9:0]  x_pos, y_pos;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lcd_sync_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_ce(pix_ce), .pix_clk(pix_clk), .hsync(hsync),
        .vsync(vsync), .de(de), .frame_start(frame_start), .x_pos(x_pos),
        .y_pos(y_pos)
    );

    // ---------------- reference model ----------------
    bit          m_go;
    logic [31:0] s_h, s_v, s_c, a_h, a_v, a_c;
    int          m_div, m_h, m_v;

    function automatic int f_sync(logic [31:0] w); return int'(w[15:10]) + 1; endfunction
    function automatic int f_abeg(logic [31:0] w); return f_sync(w) + int'(w[23:16]) + 1; endfunction
    function automatic int f_aend(logic [31:0] w); return f_abeg(w) + int'(w[9:0]) + 1; endfunction
    function automatic int f_per(logic [31:0] w);  return f_aend(w) + int'(w[31:24]) + 1; endfunction

    function automatic bit e_ce();
        return m_go && (m_div == 2 * int'(a_c[9:0]) + 1);
    endfunction
    function automatic bit e_hact();
        return m_go && m_h >= f_abeg(a_h) && m_h < f_aend(a_h);
    endfunction
    function automatic bit e_vact();
        return m_go && m_v >= f_abeg(a_v) && m_v < f_aend(a_v);
    endfunction

    // Model state update, mirroring the requirement timing
    always @(posedge clk) begin
        bit ce_now, fend;
        if (!rst_n) begin
            m_go <= 0; s_h <= 0; s_v <= 0; s_c <= 0;
            a_h <= 0; a_v <= 0; a_c <= 0; m_div <= 0; m_h <= 0; m_v <= 0;
        end else begin
            ce_now = e_ce();
            fend = ce_now && m_h == f_per(a_h) - 1 && m_v == f_per(a_v) - 1;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_go <= wr_data[0];
                    2'd1: s_h <= wr_data;
                    2'd2: s_v <= wr_data;
                    default: s_c <= wr_data;
                endcase
            end
            if (!m_go || fend) begin
                a_h <= s_h; a_v <= s_v; a_c <= s_c;
            end
            if (!m_go) begin
                m_div <= 0; m_h <= 0; m_v <= 0;
            end else begin
                m_div <= ce_now ? 0 : m_div + 1;
                if (ce_now) begin
                    if (m_h == f_per(a_h) - 1) begin
                        m_h <= 0;
                        m_v <= (m_v == f_per(a_v) - 1) ? 0 : m_v + 1;
                    end else begin
                        m_h <= m_h + 1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison of every output against the model
    always @(negedge clk) begin
        bit ce_e, pclk_e, hs_e, vs_e, de_e, fs_e, ha, va;
        int x_e, y_e;
        if (rst_n && !done) begin
            ce_e   = e_ce();
            pclk_e = (m_go && m_div > int'(a_c[9:0])) ^ a_c[17];
            hs_e   = (m_go && m_h < f_sync(a_h)) ^ a_c[16];
            vs_e   = (m_go && m_v < f_sync(a_v)) ^ a_c[15];
            ha = e_hact();
            va = e_vact();
            de_e = (ha && va) ^ a_c[18];
            x_e  = ha ? m_h - f_abeg(a_h) : 0;
            y_e  = va ? m_v - f_abeg(a_v) : 0;
            fs_e = ce_e && m_h == 0 && m_v == 0;
            checks++;
            if (pix_ce !== ce_e) begin errors++; $display("FAIL R3 pix_ce actual=%0d expected=%0d", pix_ce, ce_e); end
            if (pix_clk !== pclk_e) begin errors++; $display("FAIL R3/R7 pix_clk actual=%0d expected=%0d", pix_clk, pclk_e); end
            if (hsync !== hs_e) begin errors++; $display("FAIL R4 hsync actual=%0d expected=%0d", hsync, hs_e); end
            if (vsync !== vs_e) begin errors++; $display("FAIL R5 vsync actual=%0d expected=%0d", vsync, vs_e); end
            if (de !== de_e) begin errors++; $display("FAIL R6 de actual=%0d expected=%0d", de, de_e); end
            if (int'(x_pos) != x_e) begin errors++; $display("FAIL R6 x_pos actual=%0d expected=%0d", x_pos, x_e); end
            if (int'(y_pos) != y_e) begin errors++; $display("FAIL R6 y_pos actual=%0d expected=%0d", y_pos, y_e); end
            if (frame_start !== fs_e) begin errors++; $display("FAIL R10 frame_start actual=%0d expected=%0d", frame_start, fs_e); end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] tw(int fp, int bp, int pw, int act);
        return {8'(fp - 1), 8'(bp - 1), 6'(pw - 1), 10'(act - 1)};
    endfunction

    // Cycles from the current negedge to the next frame_start seen at a negedge
    task automatic wait_fs(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!frame_start && n < 20000);
    endtask

    initial begin
        int n1, n2;
        logic [31:0] h0, v0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk(pix_ce == 0 && de == 0 && hsync == 0 && vsync == 0 && pix_clk == 0,
            "R2 outputs idle after reset", int'({pix_ce, de, hsync, vsync, pix_clk}), 0);
        chk(x_pos == 0 && y_pos == 0 && frame_start == 0, "R2 coordinates zero", int'(x_pos), 0);

        // Small panel: H = 2+3+8+2 = 15, V = 1+2+4+1 = 8, 4 clocks per slot
        h0 = tw(2, 3, 2, 8);
        v0 = tw(1, 2, 1, 4);
        wr(2'd1, h0);
        wr(2'd2, v0);
        wr(2'd3, 32'd1);
        chk(hsync == 0, "R1 no scanning before run bit", int'(hsync), 0);
        wr(2'd0, 32'd1);
        chk(hsync == 1 && vsync == 1, "R1 run bit starts at sync origin", int'({hsync, vsync}), 3);
        wait_fs(n1);
        chk(frame_start == 1, "R10 frame_start seen", int'(frame_start), 1);
        wait_fs(n1);
        chk(n1 == 4 * 15 * 8, "R3/R4/R5 frame period", n1, 480);

        // R9: rewrite horizontal timing right after a frame start
        wr(2'd1, tw(2, 3, 2, 10));
        wait_fs(n1);
        wait_fs(n2);
        chk(n1 + 2 == 480, "R9 current frame keeps old timing", n1 + 2, 480);
        chk(n2 == 4 * 17 * 8, "R9 next frame uses new timing", n2, 544);

        // R8: stop blanks; R7: inversion applies to the stopped levels
        wr(2'd0, 32'd0);
        chk(de == 0 && hsync == 0 && pix_ce == 0 && x_pos == 0, "R8 stop blanks outputs",
            int'({de, hsync, pix_ce}), 0);
        wr(2'd3, 32'h0007_8001);
        @(negedge clk);
        chk(hsync == 1 && vsync == 1 && de == 1 && pix_clk == 1, "R7 inverted idle levels",
            int'({hsync, vsync, de, pix_clk}), 15);
        wr(2'd0, 32'd1);
        chk(hsync == 0 && vsync == 0, "R7/R8 restart at origin with inverted sync",
            int'({hsync, vsync}), 0);
        repeat (700) @(negedge clk);

        // Random scenarios, with mid-frame rewrites and stop/start
        for (int s = 0; s < 24; s++) begin
            logic [31:0] hw, vw, cw;
            hw = tw(1 + $urandom_range(0, 3), 1 + $urandom_range(0, 3),
                    1 + $urandom_range(0, 3), 1 + $urandom_range(0, 7));
            vw = tw(1 + $urandom_range(0, 1), 1 + $urandom_range(0, 1),
                    1 + $urandom_range(0, 1), 1 + $urandom_range(0, 3));
            cw = {13'd0, 4'($urandom_range(0, 15)), 5'd0, 10'($urandom_range(0, 3))};
            if ($urandom_range(0, 2) == 0) wr(2'd0, 32'd0);
            case ($urandom_range(0, 2))
                0: wr(2'd1, hw);
                1: wr(2'd2, vw);
                default: wr(2'd3, cw);
            endcase
            wr(2'd0, 32'd1);
            repeat ($urandom_range(300, 2500)) @(negedge clk);
        end

        // Directed corner: minimal one-slot fields, divisor zero
        wr(2'd0, 32'd0);
        wr(2'd1, tw(1, 1, 1, 1));
        wr(2'd2, tw(1, 1, 1, 1));
        wr(2'd3, 32'd0);
        wr(2'd0, 32'd1);
        wait_fs(n1);
        wait_fs(n1);
        chk(n1 == 2 * 4 * 4, "R3/R4 minimum timing frame period", n1, 32);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule